// File: doc/BRIEF.md
# Triggered One-Shot Pulse Timer

This block turns a rising edge on an asynchronous trigger input into a single, precisely placed pulse. The edge is first brought into the clock domain and detected. An idle up-counter then starts from zero. The output enters its pulse level when the count equals a programmed compare value and leaves it when the count reaches a programmed reload value. The distance from the trigger to the pulse is therefore set by the compare value, and the pulse length is set by the reload value minus the compare value.

In single-shot operation the counter stops and clears itself at the first rollover, ready for the next trigger. In repetitive operation the counter keeps wrapping, so the waveform repeats every reload + 1 cycles. The output stage offers two fixed levels and two pulse polarities. In the two pulse modes, an optional fast path can skip the synchroniser and comparison latency. It drives the output to its post-match level straight from the first synchroniser stage.

Top module: `opt_pulse_timer`

## Requirements
- R1: While `rst` is high at a clock edge, `pulse_out`, `running` and `update_stb` are 0 after that edge, and the counter is 0.
- R2: If `trig_in` is first sampled high at edge k (low before, held high for at least 3 cycles) while idle, `running` is 1 after edge k+2 and the count is 0 at that point.
- R3: In mode `out_mode`=2'b10 (pulse high), with compare C below reload L and fast enable off, `pulse_out` rises after edge k+2+C, so the delay equals C counter ticks.
- R4: In mode 2'b10, `pulse_out` stays high for L-C cycles and falls after the edge at which the count reaches L. If C >= L, no pulse appears.
- R5: In mode 2'b11 (pulse low), `pulse_out` is the complement of the mode 2'b10 level in every cycle. It idles high.
- R6: Mode 2'b00 holds `pulse_out` at 0 and mode 2'b01 holds it at 1, whatever the trigger and the count do.
- R7: `update_stb` is high for exactly the one cycle after each rollover from L to 0, first after edge k+3+L.
- R8: With `single_shot`=1, `running` falls at the same edge that raises `update_stb`, and the counter returns to 0. A later trigger then gives exactly the timing of R2 to R4 again.
- R9: With `single_shot`=0, the counter keeps running after each rollover, and the pulse and strobe repeat every L+1 cycles until reset.
- R10: A trigger edge that arrives while `running` is 1 changes neither the count, `running`, `update_stb` nor `pulse_out`.
- R11: With `fast_en`=1 in mode 2'b10 or 2'b11, `pulse_out` takes its post-match level after edge k+1. It holds that level until the count reaches L, in the first period only.
- R12: With `fast_en`=1 in mode 2'b00 or 2'b01, the output and the counter timing are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| trig_in | input | 1 | Asynchronous trigger, rising edge starts the timer |
| cmp_val | input | CNT_W | Compare value (delay in ticks) |
| rld_val | input | CNT_W | Reload value (last count of a period) |
| single_shot | input | 1 | 1: stop at first rollover, 0: repeat |
| out_mode | input | 2 | 00 low, 01 high, 10 pulse high, 11 pulse low |
| fast_en | input | 1 | Force post-match level directly from the trigger |
| pulse_out | output | 1 | Registered pulse output |
| running | output | 1 | Counter enabled |
| update_stb | output | 1 | One-cycle strobe after each rollover |

## Verification
All results are timed from the edge k that first samples the trigger high. The fast-path output is due after edge k+1, `running` after edge k+2, the pulse edges after k+2+C and k+2+L, and the strobe after k+3+L plus each further multiple of L+1. The bench drives inputs on the falling edge and samples every output on the falling edge after each rising edge. It compares them against functions of the cycle index i = edge - k, so every result is checked in the exact cycle it is due and in every cycle around it. Retriggers are timed so that their detection falls inside the running window.

// File: rtl/opt_pulse_pkg.sv
package opt_pulse_pkg;
   typedef enum logic [1:0] {
      OM_FORCE_LO = 2'b00,
      OM_FORCE_HI = 2'b01,
      OM_WIN_HI   = 2'b10,
      OM_WIN_LO   = 2'b11
   } out_mode_e;

   function automatic logic is_window_mode(input out_mode_e m);
      return m[1];
   endfunction
endpackage

// File: rtl/opt_pulse_sync.sv
module opt_pulse_sync #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic trig_in,
   output logic early_rise,
   output logic sync_rise
);
   localparam int CHAIN_W = SYNC_STAGES + 1;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_stages
         $error("opt_pulse_sync: SYNC_STAGES must be at least 2");
      end
   endgenerate

   // stages 0..SYNC_STAGES-1 form the synchroniser, the last bit is the
   // delayed copy used by the edge detector
   logic [CHAIN_W-1:0] chain_q;

   always_ff @(posedge clk) begin
      if (rst) chain_q <= '0;
      else     chain_q <= {chain_q[CHAIN_W-2:0], trig_in};
   end

   assign early_rise = chain_q[0] & ~chain_q[1];
   assign sync_rise  = chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];
endmodule

// File: rtl/opt_pulse_counter.sv
module opt_pulse_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start_req,
   input  logic             single_shot,
   input  logic [CNT_W-1:0] rld_val,
   output logic             run_q,
   output logic             run_n,
   output logic [CNT_W-1:0] cnt_q,
   output logic [CNT_W-1:0] cnt_n,
   output logic             wrap,
   output logic             upd_q
);
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   generate
      if (CNT_W < 2) begin : g_bad_width
         $error("opt_pulse_counter: CNT_W must be at least 2");
      end
   endgenerate

   always_comb begin
      run_n = run_q;
      cnt_n = cnt_q;
      wrap  = 1'b0;
      if (start_req && !run_q) begin
         run_n = 1'b1;
         cnt_n = '0;
      end else if (run_q) begin
         if (cnt_q == rld_val) begin
            wrap  = 1'b1;
            cnt_n = '0;
            run_n = ~single_shot;
         end else begin
            cnt_n = cnt_q + CNT_ONE;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         run_q <= 1'b0;
         cnt_q <= '0;
         upd_q <= 1'b0;
      end else begin
         run_q <= run_n;
         cnt_q <= cnt_n;
         upd_q <= wrap;
      end
   end
endmodule

// File: rtl/opt_pulse_shaper.sv
module opt_pulse_shaper
   import opt_pulse_pkg::*;
#(
   parameter int CNT_W    = 16,
   parameter bit HAS_FAST = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             early_rise,
   input  logic             run_q,
   input  logic             run_n,
   input  logic [CNT_W-1:0] cnt_n,
   input  logic             wrap,
   input  logic [CNT_W-1:0] cmp_val,
   input  logic [CNT_W-1:0] rld_val,
   input  out_mode_e        mode,
   input  logic             fast_en,
   output logic             out_q
);
   logic forced_n;
   logic win_n;
   logic out_n;

   generate
      if (HAS_FAST) begin : g_fast
         logic forced_q;
         always_comb begin
            forced_n = forced_q;
            if (wrap) forced_n = 1'b0;
            if (early_rise && fast_en && is_window_mode(mode) && !run_q)
               forced_n = 1'b1;
         end
         always_ff @(posedge clk) begin
            if (rst) forced_q <= 1'b0;
            else     forced_q <= forced_n;
         end
      end else begin : g_no_fast
         assign forced_n = 1'b0;
      end
   endgenerate

   always_comb begin
      if (run_n) win_n = (cnt_n < rld_val) && ((cnt_n >= cmp_val) || forced_n);
      else       win_n = forced_n;
   end

   always_comb begin
      case (mode)
         OM_FORCE_LO: out_n = 1'b0;
         OM_FORCE_HI: out_n = 1'b1;
         OM_WIN_HI:   out_n = win_n;
         OM_WIN_LO:   out_n = ~win_n;
         default:     out_n = 1'b0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) out_q <= 1'b0;
      else     out_q <= out_n;
   end
endmodule

// File: rtl/opt_pulse_timer.sv
module opt_pulse_timer
   import opt_pulse_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2,
   parameter bit HAS_FAST    = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             trig_in,
   input  logic [CNT_W-1:0] cmp_val,
   input  logic [CNT_W-1:0] rld_val,
   input  logic             single_shot,
   input  logic [1:0]       out_mode,
   input  logic             fast_en,
   output logic             pulse_out,
   output logic             running,
   output logic             update_stb
);
   logic             early_rise;
   logic             sync_rise;
   logic             run_n;
   logic [CNT_W-1:0] cnt_now;
   logic [CNT_W-1:0] cnt_n;
   logic             wrap;
   out_mode_e        mode;

   assign mode = out_mode_e'(out_mode);

   opt_pulse_sync #(.SYNC_STAGES(SYNC_STAGES)) i_sync (
      .clk        (clk),
      .rst        (rst),
      .trig_in    (trig_in),
      .early_rise (early_rise),
      .sync_rise  (sync_rise)
   );

   opt_pulse_counter #(.CNT_W(CNT_W)) i_cnt (
      .clk         (clk),
      .rst         (rst),
      .start_req   (sync_rise),
      .single_shot (single_shot),
      .rld_val     (rld_val),
      .run_q       (running),
      .run_n       (run_n),
      .cnt_q       (cnt_now),
      .cnt_n       (cnt_n),
      .wrap        (wrap),
      .upd_q       (update_stb)
   );

   opt_pulse_shaper #(.CNT_W(CNT_W), .HAS_FAST(HAS_FAST)) i_shape (
      .clk        (clk),
      .rst        (rst),
      .early_rise (early_rise),
      .run_q      (running),
      .run_n      (run_n),
      .cnt_n      (cnt_n),
      .wrap       (wrap),
      .cmp_val    (cmp_val),
      .rld_val    (rld_val),
      .mode       (mode),
      .fast_en    (fast_en),
      .out_q      (pulse_out)
   );
endmodule

// File: rtl/opt_pulse_checker.sv
module opt_pulse_checker #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst,
   input logic             running,
   input logic             update_stb,
   input logic             pulse_out,
   input logic [CNT_W-1:0] cnt,
   input logic [CNT_W-1:0] rld_val,
   input logic             single_shot,
   input logic [1:0]       out_mode,
   input logic             sync_rise
);
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   AST_IDLE_CNT_ZERO: assert property (@(posedge clk) disable iff (rst)
      !running |-> cnt == '0); // R8

   AST_START_FROM_EDGE: assert property (@(posedge clk) disable iff (rst)
      $rose(running) |-> $past(sync_rise)); // R2

   AST_STROBE_AT_RELOAD: assert property (@(posedge clk) disable iff (rst)
      update_stb |-> ($past(running) && $past(cnt) == $past(rld_val))); // R7

   AST_SINGLE_STOPS: assert property (@(posedge clk) disable iff (rst)
      (update_stb && $past(single_shot)) |-> !running); // R8

   AST_PULSE_ENDS_AT_RELOAD: assert property (@(posedge clk) disable iff (rst)
      (running && cnt == rld_val && out_mode == 2'b10 && $stable(out_mode) && $stable(rld_val))
      |-> !pulse_out); // R4

   AST_FIXED_LOW: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(out_mode) == 2'b00) |-> !pulse_out); // R6

   AST_FIXED_HIGH: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(out_mode) == 2'b01) |-> pulse_out); // R6

   AST_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
      (running && $past(running) && !$past(rst) && $past(cnt) != $past(rld_val))
      |-> cnt == ($past(cnt) + CNT_ONE)); // R10
endmodule

bind opt_pulse_timer opt_pulse_checker #(.CNT_W(CNT_W)) i_chk (
   .clk         (clk),
   .rst         (rst),
   .running     (running),
   .update_stb  (update_stb),
   .pulse_out   (pulse_out),
   .cnt         (cnt_now),
   .rld_val     (rld_val),
   .single_shot (single_shot),
   .out_mode    (out_mode),
   .sync_rise   (sync_rise)
);

// File: tb/test_opt_pulse_timer.sv
module test_opt_pulse_timer;
   localparam int CLK_PERIOD = 10;
   localparam int CNT_W      = 16;

   logic             clk = 1'b0;
   logic             rst = 1'b1;
   logic             trig_in = 1'b0;
   logic [CNT_W-1:0] cmp_val = '0;
   logic [CNT_W-1:0] rld_val = '0;
   logic             single_shot = 1'b1;
   logic [1:0]       out_mode = 2'b10;
   logic             fast_en = 1'b0;
   logic             pulse_out, running, update_stb;

   int n_checks = 0;
   int n_errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   opt_pulse_timer #(.CNT_W(CNT_W)) i_opt_pulse_timer (
      .clk(clk), .rst(rst), .trig_in(trig_in), .cmp_val(cmp_val),
      .rld_val(rld_val), .single_shot(single_shot), .out_mode(out_mode),
      .fast_en(fast_en), .pulse_out(pulse_out), .running(running),
      .update_stb(update_stb)
   );

   task automatic check(input logic act, input logic exp, input string tag, input string what);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s %s at %0t: actual=%0b expected=%0b", tag, what, $time, act, exp);
      end
   endtask

   // i = number of rising edges after the edge k that first samples the trigger high
   function automatic bit exp_run(int i, int l, bit s);
      return (i >= 2) && (!s || i <= l + 2);
   endfunction

   function automatic bit exp_upd(int i, int l, bit s);
      if (i < 3 || ((i - 2) % (l + 1)) != 0) return 1'b0;
      return !s || (i == l + 3);
   endfunction

   function automatic bit exp_win(int i, int c, int l, bit s, bit[1:0] m, bit f);
      bit fa = f && m[1];
      bit r = exp_run(i, l, s);
      int ph = r ? (i - 2) % (l + 1) : 0;
      if (fa && i == 1) return 1'b1;
      return r && (ph < l) && ((ph >= c) || (fa && (i - 2) < l));
   endfunction

   function automatic bit exp_out(int i, int c, int l, bit s, bit[1:0] m, bit f);
      case (m)
         2'b00:   return 1'b0;
         2'b01:   return 1'b1;
         2'b10:   return exp_win(i, c, l, s, m, f);
         default: return !exp_win(i, c, l, s, m, f);
      endcase
   endfunction

   task automatic pulse_reset();
      @(negedge clk); rst = 1'b1;
      @(negedge clk); rst = 1'b0;
   endtask

   task automatic scenario(input int c, input int l, input bit s, input bit [1:0] m,
                           input bit f, input bit rt, input string tag);
      int len;
      bit do_rt;
      string rtag, otag;
      do_rt = rt && (l >= 5 || !s);
      cmp_val = CNT_W'(c); rld_val = CNT_W'(l); single_shot = s;
      out_mode = m; fast_en = f;
      repeat (4) @(negedge clk);
      trig_in = 1'b1;
      len = s ? l + 8 : 2 * (l + 1) + 8;
      for (int i = 0; i < len; i++) begin
         @(posedge clk); @(negedge clk);
         rtag = do_rt ? "R10" : ((i <= 2) ? "R2" : (s ? "R8" : "R9"));
         otag = do_rt ? "R10" : tag;
         check(running,    exp_run(i, l, s),             rtag, "running");
         check(update_stb, exp_upd(i, l, s),             do_rt ? "R10" : "R7", "update_stb");
         check(pulse_out,  exp_out(i, c, l, s, m, f),    otag, "pulse_out");
         if (i == 2) trig_in = 1'b0;
         if (do_rt && i == 4) trig_in = 1'b1;
         if (do_rt && i == 6) trig_in = 1'b0;
      end
      trig_in = 1'b0;
      if (!s) pulse_reset();
   endtask

   initial begin
      repeat (CLK_PERIOD * 0 + 200000) @(posedge clk);
      if (!done) begin
         n_errors++;
         n_checks++;
         $display("FAIL watchdog expired: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4321));
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(pulse_out,  1'b0, "R1", "pulse_out in reset");
      check(running,    1'b0, "R1", "running in reset");
      check(update_stb, 1'b0, "R1", "update_stb in reset");
      rst = 1'b0;

      // directed corner cases
      scenario(3, 8, 1, 2'b10, 0, 0, "R3");   // delay then width
      scenario(3, 8, 1, 2'b10, 0, 0, "R8");   // same again: counter was cleared
      scenario(0, 4, 1, 2'b10, 0, 0, "R3");   // zero delay
      scenario(5, 5, 1, 2'b10, 0, 0, "R4");   // compare equals reload: no pulse
      scenario(7, 3, 1, 2'b10, 0, 0, "R4");   // compare beyond reload
      scenario(2, 6, 1, 2'b11, 0, 0, "R5");
      scenario(2, 6, 1, 2'b00, 0, 0, "R6");
      scenario(2, 6, 1, 2'b01, 0, 0, "R6");
      scenario(0, 0, 1, 2'b10, 0, 0, "R7");   // reload zero
      scenario(2, 5, 0, 2'b10, 0, 0, "R9");
      scenario(1, 3, 0, 2'b11, 0, 0, "R9");
      scenario(2, 10, 1, 2'b10, 0, 1, "R10");
      scenario(3, 9, 0, 2'b10, 0, 1, "R10");
      scenario(6, 9, 1, 2'b10, 1, 0, "R11");
      scenario(6, 9, 1, 2'b11, 1, 0, "R11");
      scenario(4, 7, 0, 2'b10, 1, 0, "R11");
      scenario(0, 0, 1, 2'b10, 1, 0, "R11");
      scenario(3, 7, 1, 2'b01, 1, 0, "R12");
      scenario(3, 7, 1, 2'b00, 1, 0, "R12");

      // constrained random
      for (int n = 0; n < 40; n++) begin
         int l, c;
         bit s, f, rt;
         bit [1:0] m;
         string t;
         l  = int'($urandom % 20);
         c  = int'($urandom % (l + 3));
         s  = 1'($urandom % 2);
         m  = 2'($urandom % 4);
         f  = 1'($urandom % 2);
         rt = 1'($urandom % 2);
         if (f) t = m[1] ? "R11" : "R12";
         else if (m == 2'b11) t = "R5";
         else if (m[1]) t = "R4";
         else t = "R6";
         scenario(c, l, s, m, f, rt, t);
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end
endmodule